// File: doc/BRIEF.md
# Dual-Mode Signal-Field Check Sequence Generator

This block computes the check sequence that protects a short serial header. Header bits arrive one per clock, most significant first, each qualified by a valid strobe. The last one is marked by a final-bit flag. A one-cycle start strobe opens a frame. It also selects one of three results: a full 8-bit CRC, a truncated 4-bit value made of the low bits of that 8-bit CRC, or a true 4-bit CRC. A new start strobe always re-opens the frame, even if another frame is still in progress.

Both CRC widths share one shift register. In 4-bit CRC mode the feedback is taken from stage 3 instead of stage 7, and it is injected only into the two lowest stages. In that mode the upper stages are not clocked. When the final bit has been taken in, the result is driven in parallel and held. It is then shifted out serially, first bit first. A compare output tells a receiver whether a check field it supplies equals the recomputed value. The truncated mode exists for compatibility: unlike the true 4-bit CRC, it does not catch every single-bit error in a 26-bit payload.

Top module: `sigcrc_dual`

## Requirements
- R1: While reset is asserted, and after it is released with no frame run yet, `crc_vld_o`, `ser_vld_o` and `match_o` are all 0.
- R2: `start_i` presets every register stage to one and aborts any frame in progress. A valid data bit offered in the same cycle as `start_i` is discarded.
- R3: A data bit is taken in only in a cycle where `bit_valid_i` is 1 inside an open frame. Cycles with `bit_valid_i` at 0 have no effect on the result.
- R4: Mode code 2'b00, and also the spare code 2'b11, gives the 8-bit CRC with generator x^8+x^2+x+1. The register is preset to all ones, the final contents are inverted, and the stage fed last by the feedback appears on `crc_par_o[7]`.
- R5: Mode code 2'b01 gives `crc_par_o[3:0]` equal to the low four bits of the mode-2'b00 result over the same bits, with `crc_par_o[7:4]` = 0.
- R6: Mode code 2'b10 gives a 4-bit CRC with generator x^4+x+1, with the same preset and inversion, on `crc_par_o[3:0]`, with `crc_par_o[7:4]` = 0.
- R7: The mode is captured at `start_i`. Changing `mode_i` during the frame has no effect on that frame.
- R8: A valid bit with `last_i` = 1 closes the frame. `crc_vld_o` is then 1 for exactly the next cycle, and `crc_par_o` holds the result until the next `start_i`. Valid bits offered after the frame is closed are ignored.
- R9: Starting the cycle after the `crc_vld_o` pulse, `ser_vld_o` is 1 for 8 cycles (4 in modes 2'b01 and 2'b10). During those cycles `ser_bit_o` carries the result from its top bit downward. A `start_i` stops the serial output.
- R10: `match_o` is 1 while a result is held and `rx_chk_i` equals it over the active width. The active width is all 8 bits in 8-bit modes and bits [3:0] in 4-bit modes. `start_i` clears it.
- R11: In mode 2'b10, flipping any single bit of a 26-bit payload changes the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Frame start strobe; captures mode |
| mode_i | input | 2 | 00/11 8-bit CRC, 01 truncated 8-bit, 10 4-bit CRC |
| bit_valid_i | input | 1 | Data bit qualifier |
| bit_i | input | 1 | Serial data bit, most significant first |
| last_i | input | 1 | Marks the final data bit of the frame |
| rx_chk_i | input | 8 | Received check bits to compare against |
| crc_par_o | output | 8 | Parallel result, right-aligned in 4-bit modes |
| crc_vld_o | output | 1 | One-cycle pulse when the result becomes valid |
| ser_bit_o | output | 1 | Serial result bit |
| ser_vld_o | output | 1 | Serial result qualifier |
| match_o | output | 1 | Received check bits equal the computed result |

## Verification
The final data bit is registered on clock edge N. `crc_vld_o` and the parallel result are therefore due in the cycle after edge N. The first serial bit appears after edge N+1, and the serial qualifier drops after edge N+W+1. The bench drives all inputs on falling edges and samples on the next falling edge, which keeps each sample one register stage after the edge that produced it. `match_o` is combinational from the held result, so the bench changes `rx_chk_i` and samples 1 ns later, well away from any rising edge. The bench runs random payloads in all four mode codes, and every single-bit flip of a fixed 26-bit payload in each of the three modes. Each result is compared against a bitwise model computed in the bench.

// File: rtl/sigcrc_pkg.sv
package sigcrc_pkg;

  typedef enum logic [1:0] {
    MODE_WIDE   = 2'b00,
    MODE_LEGACY = 2'b01,
    MODE_NARROW = 2'b10,
    MODE_SPARE  = 2'b11
  } crc_mode_e;

  // True when the frame reports only the low four result bits.
  function automatic logic short_result(crc_mode_e m);
    return (m == MODE_LEGACY) || (m == MODE_NARROW);
  endfunction

endpackage

// File: rtl/sigcrc_ctrl.sv
module sigcrc_ctrl
  import sigcrc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  crc_mode_e mode_i,
  input  logic      bit_valid_i,
  input  logic      last_i,
  output logic      init_o,
  output logic      step_o,
  output logic      done_o,
  output logic      res_valid_o,
  output crc_mode_e mode_o
);

  logic      active_q, active_d;
  logic      done_q, done_d;
  logic      resv_q, resv_d;
  crc_mode_e mode_q;
  logic      step, fin;

  // next-state
  always_comb begin
    step     = active_q & bit_valid_i & ~start_i;
    fin      = step & last_i;
    active_d = active_q;
    resv_d   = resv_q;
    done_d   = fin;
    if (start_i) begin
      active_d = 1'b1;
      resv_d   = 1'b0;
    end else if (fin) begin
      active_d = 1'b0;
      resv_d   = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      resv_q   <= 1'b0;
      mode_q   <= MODE_WIDE;
    end else begin
      active_q <= active_d;
      done_q   <= done_d;
      resv_q   <= resv_d;
      if (start_i) begin
        mode_q <= mode_i;
      end
    end
  end

  assign init_o      = start_i;
  assign step_o      = step;
  assign done_o      = done_q;
  assign res_valid_o = resv_q;
  assign mode_o      = mode_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start_i |=> $stable(mode_q));

  // R2
  start_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_q && !resv_q && !done_q));

endmodule

// File: rtl/sigcrc_lfsr.sv
module sigcrc_lfsr #(
  parameter int                  WIDE_W      = 8,
  parameter int                  NARROW_W    = 4,
  parameter logic [WIDE_W-1:0]   POLY_WIDE   = 8'h07,
  parameter logic [NARROW_W-1:0] POLY_NARROW = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              narrow_i,
  input  logic              bit_i,
  output logic [WIDE_W-1:0] state_o
);

  localparam int HI_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] state_q, state_d, shift_d, taps;
  logic              fb;
  logic              en_lo, en_hi;

  // Feedback source mux and tap mux: the only parts that differ by width.
  always_comb begin
    fb   = (narrow_i ? state_q[NARROW_W-1] : state_q[WIDE_W-1]) ^ bit_i;
    taps = narrow_i ? {{HI_W{1'b0}}, POLY_NARROW} : POLY_WIDE;
  end

  for (genvar i = 0; i < WIDE_W; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign shift_d[0] = fb;
    end else begin : g_body
      assign shift_d[i] = state_q[i-1] ^ (taps[i] & fb);
    end
  end

  always_comb begin
    state_d = init_i ? {WIDE_W{1'b1}} : shift_d;
    en_lo   = init_i | step_i;
    en_hi   = init_i | (step_i & ~narrow_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= {WIDE_W{1'b1}};
    end else begin
      if (en_lo) begin
        state_q[NARROW_W-1:0] <= state_d[NARROW_W-1:0];
      end
      if (en_hi) begin
        state_q[WIDE_W-1:NARROW_W] <= state_d[WIDE_W-1:NARROW_W];
      end
    end
  end

  assign state_o = state_q;

  // R2
  preset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_i |=> (state_q == {WIDE_W{1'b1}}));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!init_i && !step_i) |=> $stable(state_q));

  // R6
  upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (narrow_i && !init_i) |=> $stable(state_q[WIDE_W-1:NARROW_W]));

endmodule

// File: rtl/sigcrc_ser.sv
module sigcrc_ser #(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_i,
  input  logic              load_i,
  input  logic              short_i,
  input  logic [WIDE_W-1:0] par_i,
  output logic              ser_bit_o,
  output logic              ser_vld_o
);

  localparam int CNT_W = $clog2(WIDE_W + 1);
  localparam int HI_W  = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              busy;

  always_comb begin
    busy  = (cnt_q != '0);
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (abort_i) begin
      cnt_d = '0;
    end else if (load_i) begin
      sh_d  = short_i ? {par_i[NARROW_W-1:0], {HI_W{1'b0}}} : par_i;
      cnt_d = short_i ? CNT_W'(NARROW_W) : CNT_W'(WIDE_W);
    end else if (busy) begin
      sh_d  = {sh_q[WIDE_W-2:0], 1'b0};
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  assign ser_bit_o = sh_q[WIDE_W-1];
  assign ser_vld_o = busy;

  // R9
  ser_begin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !abort_i) |=> ser_vld_o);

  // R9
  ser_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> !ser_vld_o);

  // R9
  ser_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CNT_W'(1) && !load_i) |=> !ser_vld_o);

endmodule

// File: rtl/sigcrc_match.sv
module sigcrc_match #(
  parameter int WIDE_W   = 8,
  parameter int NARROW_W = 4
) (
  input  logic              short_i,
  input  logic              res_valid_i,
  input  logic [WIDE_W-1:0] calc_i,
  input  logic [WIDE_W-1:0] rx_i,
  output logic              match_o
);

  localparam int HI_W = WIDE_W - NARROW_W;

  logic [WIDE_W-1:0] mask, diff;

  always_comb begin
    mask    = short_i ? {{HI_W{1'b0}}, {NARROW_W{1'b1}}} : {WIDE_W{1'b1}};
    diff    = (calc_i ^ rx_i) & mask;
    match_o = res_valid_i && (diff == '0);
  end

endmodule

// File: rtl/sigcrc_dual.sv
module sigcrc_dual
  import sigcrc_pkg::*;
#(
  parameter int                  WIDE_W      = 8,
  parameter int                  NARROW_W    = 4,
  parameter logic [WIDE_W-1:0]   POLY_WIDE   = 8'h07,
  parameter logic [NARROW_W-1:0] POLY_NARROW = 4'h3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        mode_i,
  input  logic              bit_valid_i,
  input  logic              bit_i,
  input  logic              last_i,
  input  logic [WIDE_W-1:0] rx_chk_i,
  output logic [WIDE_W-1:0] crc_par_o,
  output logic              crc_vld_o,
  output logic              ser_bit_o,
  output logic              ser_vld_o,
  output logic              match_o
);

  logic [1:0]        rs_q;
  logic              rst_int_n;
  logic              init, step, done, resv;
  crc_mode_e         mode_q;
  logic              narrow, short_w;
  logic [WIDE_W-1:0] state, par;

  // Reset: asserted at once, released after two clock edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  sigcrc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .start_i     (start_i),
    .mode_i      (crc_mode_e'(mode_i)),
    .bit_valid_i (bit_valid_i),
    .last_i      (last_i),
    .init_o      (init),
    .step_o      (step),
    .done_o      (done),
    .res_valid_o (resv),
    .mode_o      (mode_q)
  );

  always_comb begin
    narrow  = (mode_q == MODE_NARROW);
    short_w = short_result(mode_q);
  end

  sigcrc_lfsr #(
    .WIDE_W      (WIDE_W),
    .NARROW_W    (NARROW_W),
    .POLY_WIDE   (POLY_WIDE),
    .POLY_NARROW (POLY_NARROW)
  ) u_lfsr (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .init_i   (init),
    .step_i   (step),
    .narrow_i (narrow),
    .bit_i    (bit_i),
    .state_o  (state)
  );

  // Output shaping: inverted contents, low bits only in the 4-bit modes.
  always_comb begin
    par = '0;
    if (short_w) begin
      par[NARROW_W-1:0] = ~state[NARROW_W-1:0];
    end else begin
      par = ~state;
    end
  end

  sigcrc_ser #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) u_ser (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .abort_i   (init),
    .load_i    (done),
    .short_i   (short_w),
    .par_i     (par),
    .ser_bit_o (ser_bit_o),
    .ser_vld_o (ser_vld_o)
  );

  sigcrc_match #(
    .WIDE_W   (WIDE_W),
    .NARROW_W (NARROW_W)
  ) u_match (
    .short_i     (short_w),
    .res_valid_i (resv),
    .calc_i      (par),
    .rx_i        (rx_chk_i),
    .match_o     (match_o)
  );

  assign crc_par_o = par;
  assign crc_vld_o = done;

  // R10
  match_clear_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    start_i |=> !match_o);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (resv && !start_i) |=> $stable(crc_par_o));

endmodule

// File: tb/sigcrc_dual_tb_top.sv
module sigcrc_dual_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_i, bit_valid_i, bit_i, last_i;
  logic [1:0] mode_i;
  logic [7:0] rx_chk_i;
  logic [7:0] crc_par_o;
  logic       crc_vld_o, ser_bit_o, ser_vld_o, match_o;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  sigcrc_dual dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .mode_i      (mode_i),
    .bit_valid_i (bit_valid_i),
    .bit_i       (bit_i),
    .last_i      (last_i),
    .rx_chk_i    (rx_chk_i),
    .crc_par_o   (crc_par_o),
    .crc_vld_o   (crc_vld_o),
    .ser_bit_o   (ser_bit_o),
    .ser_vld_o   (ser_vld_o),
    .match_o     (match_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bitwise model: preset ones, MSB-first shift, invert, truncate in 4-bit modes.
  function automatic logic [7:0] ref_crc(input int mode, input logic [25:0] d, input int n);
    int         w;
    logic [7:0] poly, mask, c, r;
    logic       fb;
    w    = (mode == 2) ? 4 : 8;
    poly = (mode == 2) ? 8'h03 : 8'h07;
    mask = (w == 4) ? 8'h0F : 8'hFF;
    c    = mask;
    for (int i = n - 1; i >= 0; i--) begin
      fb = c[w-1] ^ d[i];
      c  = ((c << 1) & mask) ^ (fb ? poly : 8'h00);
    end
    r = ~c;
    if (mode == 1 || mode == 2) r = r & 8'h0F;
    return r;
  endfunction

  function automatic string mode_req(input int mode);
    if (mode == 1) return "R5";
    if (mode == 2) return "R6";
    return "R4";
  endfunction

  task automatic do_start(input int mode, input logic with_bit, input logic bv);
    start_i     = 1'b1;
    mode_i      = 2'(mode);
    bit_valid_i = with_bit;
    bit_i       = bv;
    last_i      = 1'b0;
    @(negedge clk);
    start_i     = 1'b0;
    bit_valid_i = 1'b0;
  endtask

  task automatic put_bits(input logic [25:0] d, input int n, input bit gaps, input bit with_last);
    for (int i = n - 1; i >= 0; i--) begin
      if (gaps && (i % 4 == 1)) begin
        bit_valid_i = 1'b0;
        bit_i       = ~d[i];
        @(negedge clk);
      end
      bit_valid_i = 1'b1;
      bit_i       = d[i];
      last_i      = with_last && (i == 0);
      @(negedge clk);
    end
    bit_valid_i = 1'b0;
    last_i      = 1'b0;
  endtask

  // Called at the falling edge right after the final bit was registered.
  task automatic collect_check(input int mode, input logic [25:0] d, input int n,
                               input string tag, output logic [7:0] par);
    logic [7:0] exp, sw;
    int         w;
    bit         vld_ok;
    exp = ref_crc(mode, d, n);
    chk({tag, " R8 crc_vld pulse"}, crc_vld_o, 1);
    chk({tag, " ", mode_req(mode), " parallel result"}, crc_par_o, exp);
    par    = crc_par_o;
    w      = (mode == 1 || mode == 2) ? 4 : 8;
    sw     = 8'h00;
    vld_ok = 1'b1;
    for (int k = 0; k < w; k++) begin
      @(negedge clk);
      sw = {sw[6:0], ser_bit_o};
      if (!ser_vld_o) vld_ok = 1'b0;
      if (k == 0) chk({tag, " R8 crc_vld one cycle"}, crc_vld_o, 0);
    end
    chk({tag, " R9 serial bits"}, sw, exp);
    chk({tag, " R9 serial valid length"}, vld_ok, 1);
    @(negedge clk);
    chk({tag, " R9 serial valid drops"}, ser_vld_o, 0);
    rx_chk_i = exp;
    #1;
    chk({tag, " R10 match equal"}, match_o, 1);
    rx_chk_i = exp ^ 8'h01;
    #1;
    chk({tag, " R10 match differs"}, match_o, 0);
    if (w == 4) begin
      rx_chk_i = exp ^ 8'hA0;
      #1;
      chk({tag, " R10 upper bits ignored"}, match_o, 1);
    end
    rx_chk_i = 8'h00;
  endtask

  task automatic run_frame(input int mode, input logic [25:0] d, input int n,
                           input bit gaps, input string tag, output logic [7:0] par);
    do_start(mode, 1'b0, 1'b0);
    put_bits(d, n, gaps, 1'b1);
    collect_check(mode, d, n, tag, par);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed;
    logic [25:0] d, base;
    logic [7:0]  par, bp;
    int          und [3];
    int          model_und;

    rst_n = 1'b0; start_i = 1'b0; bit_valid_i = 1'b0; bit_i = 1'b0;
    last_i = 1'b0; mode_i = 2'b00; rx_chk_i = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 vld in reset", crc_vld_o, 0);
    chk("R1 ser_vld in reset", ser_vld_o, 0);
    chk("R1 match in reset", match_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 vld after reset", crc_vld_o, 0);
    chk("R1 ser_vld after reset", ser_vld_o, 0);
    chk("R1 match after reset", match_o, 0);

    // Random payloads in every mode code, with and without valid gaps (R3).
    seed = 32'h1234_5678;
    for (int m = 0; m < 4; m++) begin
      for (int j = 0; j < 8; j++) begin
        seed = seed * 32'd1103515245 + 32'd12345;
        d    = seed[30:5];
        run_frame(m, d, (j == 7) ? 8 : 26, j[0], "sweep R3", par);
      end
    end

    // Single-bit flip sweep in the three modes.
    base = 26'h2A5_3C1;
    for (int m = 0; m < 3; m++) begin
      und[m] = 0;
      run_frame(m, base, 26, 1'b0, "flip base", bp);
      for (int f = 0; f < 26; f++) begin
        run_frame(m, base ^ (26'd1 << f), 26, 1'b0, "flip", par);
        if (par == bp) und[m]++;
      end
    end
    chk("R11 every flip detected in 4-bit CRC mode", und[2], 0);
    chk("R4 every flip detected in 8-bit mode", und[0], 0);
    model_und = 0;
    for (int f = 0; f < 26; f++) begin
      if (ref_crc(1, base ^ (26'd1 << f), 26) == ref_crc(1, base, 26)) model_und++;
    end
    chk("R5 undetected flips in truncated mode", und[1], model_und);
    $display("truncated mode: %0d of 26 single flips undetected", und[1]);

    // R2: restart in the middle of a frame.
    do_start(2, 1'b0, 1'b0);
    put_bits(26'h3FF_FFFF, 10, 1'b0, 1'b0);
    run_frame(0, 26'h155_5555, 26, 1'b0, "R2 restart", par);

    // R2: a valid bit together with start is discarded.
    do_start(0, 1'b1, 1'b1);
    put_bits(26'h0F0_F0F0, 26, 1'b0, 1'b1);
    collect_check(0, 26'h0F0_F0F0, 26, "R2 start wins", par);

    // R7: mode changes during the frame are ignored.
    do_start(2, 1'b0, 1'b0);
    mode_i = 2'b00;
    put_bits(26'h123_4567, 26, 1'b0, 1'b1);
    collect_check(2, 26'h123_4567, 26, "R7 mode held", par);

    // R8: bits after the frame closed are ignored.
    put_bits(26'h15, 5, 1'b0, 1'b1);
    chk("R8 no pulse after closed frame", crc_vld_o, 0);
    chk("R8 result held after closed frame", crc_par_o, par);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule